// File: doc/BRIEF.md
# Exclusive Two-Level Victim Cache Controller

This block keeps the tags, valid bits and replacement state of a small two-level cache in which the two levels never hold the same line. A core presents one load at a time as a byte address through a valid/ready handshake. The controller looks in the first level. If that misses, it looks in the second level. If both miss, it asks the level below for the line. It then returns a one-cycle response that reports where the line came from.

The second level is a victim store. It is written only with lines pushed out of the first level. When a line is found in the second level, it moves up into the first level and leaves the second level in the same step. If that move also pushes a first-level line out, the pushed line takes the slot just vacated. When a line has to be fetched from below, it goes straight into the first level. When the second level is full and must take a victim, it drops its pseudo-LRU line and reports that line on a one-cycle eviction output for the level below.

Top module: `xvc_ctrl`

## Requirements
- R1: After a synchronous reset, req_ready is 1, rsp_valid, fill_valid and evict_valid are 0, and every line is invalid, so a line present before reset misses afterwards.
- R2: The low 6 address bits are the byte offset within a 64-byte line and take no part in lookup. Two addresses that differ only in those bits hit the same line.
- R3: A first-level hit pulses rsp_valid for one cycle, exactly 3 clock edges after the accepting edge, with rsp_src = 0.
- R4: On a miss in both levels, fill_valid rises 3 edges after acceptance, with fill_addr equal to the request address with its low 6 bits cleared. It stays high, with fill_addr stable, up to and including the edge where fill_done is sampled 1. rsp_valid with rsp_src = 2 follows in the next cycle.
- R5: A line fetched from below is installed in the first level only, so the next request for it hits the first level.
- R6: The first level has 2 ways per set, uses true LRU, and fills an invalid way (way 0 first) before replacing. A hit makes the hit way most recent.
- R7: A line replaced in the first level is placed in the second level. A later request for it reports rsp_src = 1, with rsp_valid 12 edges after acceptance.
- R8: A second-level hit moves the line into the first level and removes it from the second level, so the next request for it hits the first level. No line is ever found in both levels.
- R9: When a second-level hit also replaces a first-level line that maps to the same second-level set, that victim takes the vacated way. No eviction is issued.
- R10: When a first-level victim enters a full second-level set, the displaced line is reported by a one-cycle evict_valid pulse, with evict_addr equal to its line address and the low 6 bits 0. For a fill from below, the pulse falls in the same cycle as rsp_valid.
- R11: Each second-level set uses a tree pseudo-LRU over its 8 ways. The way filled with the fewest recent insertions on its tree path is evicted. With ways filled 0 to 7 in order, way 0 goes first, then way 4, then way 2.
- R12: Only one request is in flight. req_ready is 0 from the accepting edge through the rsp_valid cycle. A request held on the port meanwhile is not taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_addr | input | ADDR_W | Byte address of the load |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_src | output | 2 | Source of the line: 0 first level, 1 second level, 2 below |
| fill_valid | output | 1 | Line fetch from below pending |
| fill_addr | output | ADDR_W | Line-aligned address of the fetch |
| fill_done | input | 1 | Fetched line available this cycle |
| evict_valid | output | 1 | One-cycle eviction pulse toward the level below |
| evict_addr | output | ADDR_W | Line-aligned address of the evicted line |

## Verification
A corrupted valid bit or tag appears at the ports on the next request to that line, as a wrong rsp_src and a response latency of 3, 12 or 4 edges instead of the expected one. Wrong LRU or pseudo-LRU state stays hidden until a set fills. It then appears as the wrong evict_addr, or as a line reported from below that should have come from the second level. The request sequence therefore fills one set in both levels completely, then forces three evictions and a swap, so the replacement order is checked directly.

// File: rtl/xvc_pkg.sv
package xvc_pkg;

    localparam int OFFSET_W = 6;

    typedef enum logic [1:0] {
        SRC_L1  = 2'd0,
        SRC_L2  = 2'd1,
        SRC_MEM = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_L1LOOK,
        ST_L2WAIT,
        ST_FILL,
        ST_RESP
    } state_e;

endpackage

// File: rtl/xvc_l1.sv
module xvc_l1 #(
    parameter int LINE_W = 26,
    parameter int SETS   = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LINE_W-1:0] lk_line,
    output logic              hit,
    output logic              hit_way,
    output logic              vic_valid,
    output logic [LINE_W-1:0] vic_line,
    input  logic              touch_en,
    input  logic              ins_en
);
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = LINE_W - IDX_W;

    logic [TAG_W-1:0] tag_q   [SETS][2];
    logic [1:0]       valid_q [SETS];
    logic [SETS-1:0]  lru_q;

    logic [IDX_W-1:0] set_i;
    logic [TAG_W-1:0] tag_i;
    logic [1:0]       way_hit;
    logic             vway;

    assign set_i = lk_line[IDX_W-1:0];
    assign tag_i = lk_line[LINE_W-1:IDX_W];

    for (genvar w = 0; w < 2; w++) begin : g_match
        assign way_hit[w] = valid_q[set_i][w] && (tag_q[set_i][w] == tag_i);
    end

    assign hit     = |way_hit;
    assign hit_way = way_hit[1];

    always_comb begin
        if (!valid_q[set_i][0])      vway = 1'b0;
        else if (!valid_q[set_i][1]) vway = 1'b1;
        else                         vway = lru_q[set_i];
    end

    assign vic_valid = &valid_q[set_i];
    assign vic_line  = {tag_q[set_i][vway], set_i};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) valid_q[s] <= '0;
            lru_q <= '0;
        end else begin
            if (touch_en) lru_q[set_i] <= ~hit_way;
            if (ins_en) begin
                valid_q[set_i][vway] <= 1'b1;
                lru_q[set_i]         <= ~vway;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) tag_q[set_i][vway] <= tag_i;
    end

    AST_L1_NO_DUP: assert property (@(posedge clk) disable iff (rst)
        ins_en |-> !hit) else $error("line installed twice in level one"); // R5

endmodule

// File: rtl/xvc_l2.sv
module xvc_l2 #(
    parameter int LINE_W = 26,
    parameter int SETS   = 8,
    parameter int WAYS   = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [LINE_W-1:0]        lk_line,
    output logic                     hit,
    output logic [$clog2(WAYS)-1:0]  hit_way,
    input  logic                     inv_en,
    input  logic                     ins_en,
    input  logic [LINE_W-1:0]        ins_line,
    input  logic                     ins_swap,
    output logic                     ev_valid,
    output logic [LINE_W-1:0]        ev_line
);
    localparam int IDX_W  = $clog2(SETS);
    localparam int TAG_W  = LINE_W - IDX_W;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;

    logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
    logic [WAYS-1:0]   valid_q [SETS];
    logic [TREE_W-1:0] tree_q  [SETS];

    function automatic logic [WAY_W-1:0] plru_pick(input logic [TREE_W-1:0] t);
        logic [WAY_W-1:0] w;
        int n;
        logic b;
        w = '0;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            b = t[n];
            w = WAY_W'({w, b});
            n = 2 * n + 1 + int'(b);
        end
        return w;
    endfunction

    function automatic logic [TREE_W-1:0] plru_touch(input logic [TREE_W-1:0] t,
                                                     input logic [WAY_W-1:0] way);
        logic [TREE_W-1:0] r;
        int n;
        logic b;
        r = t;
        n = 0;
        for (int l = 0; l < WAY_W; l++) begin
            b    = way[WAY_W-1-l];
            r[n] = ~b;
            n    = 2 * n + 1 + int'(b);
        end
        return r;
    endfunction

    logic [IDX_W-1:0] lset, iset;
    logic [TAG_W-1:0] ltag, itag;
    logic [WAYS-1:0]  match;
    logic [WAY_W-1:0] free_way, pick_way, vway, ins_way;
    logic             has_free;

    assign lset = lk_line[IDX_W-1:0];
    assign ltag = lk_line[LINE_W-1:IDX_W];
    assign iset = ins_line[IDX_W-1:0];
    assign itag = ins_line[LINE_W-1:IDX_W];

    for (genvar w = 0; w < WAYS; w++) begin : g_match
        assign match[w] = valid_q[lset][w] && (tag_q[lset][w] == ltag);
    end

    assign hit = |match;

    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++)
            if (match[w]) hit_way = WAY_W'(w);
    end

    always_comb begin
        free_way = '0;
        has_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_q[iset][w]) begin
                free_way = WAY_W'(w);
                has_free = 1'b1;
            end
        end
    end

    assign pick_way = plru_pick(tree_q[iset]);
    assign vway     = has_free ? free_way : pick_way;
    assign ins_way  = ins_swap ? hit_way : vway;
    assign ev_valid = !has_free;
    assign ev_line  = {tag_q[iset][pick_way], iset};

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                valid_q[s] <= '0;
                tree_q[s]  <= '0;
            end
        end else begin
            if (inv_en) valid_q[lset][hit_way] <= 1'b0;
            if (ins_en) begin
                valid_q[iset][ins_way] <= 1'b1;
                tree_q[iset]           <= plru_touch(tree_q[iset], ins_way);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (ins_en) tag_q[iset][ins_way] <= itag;
    end

    AST_L2_INV_ON_HIT: assert property (@(posedge clk) disable iff (rst)
        inv_en |-> hit) else $error("level two invalidate without a hit"); // R8

endmodule

// File: rtl/xvc_ctrl.sv
module xvc_ctrl
    import xvc_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int L1_SETS  = 8,
    parameter int L2_SETS  = 8,
    parameter int L2_WAYS  = 8,
    parameter int L1_LAT   = 3,
    parameter int L2_EXTRA = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              rsp_valid,
    output logic [1:0]        rsp_src,
    output logic              fill_valid,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_done,
    output logic              evict_valid,
    output logic [ADDR_W-1:0] evict_addr
);
    localparam int LINE_W   = ADDR_W - OFFSET_W;
    localparam int L2_IDX_W = $clog2(L2_SETS);
    localparam int MAX_LAT  = (L1_LAT > L2_EXTRA) ? L1_LAT : L2_EXTRA;
    localparam int CNT_W    = $clog2(MAX_LAT + 1);
    localparam int L2_WAY_W = $clog2(L2_WAYS);

    state_e              state_q;
    src_e                src_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [LINE_W-1:0]   line_q;
    logic                evict_q;
    logic [LINE_W-1:0]   evict_line_q;

    logic                l1_hit, l1_hit_way, l1_vic_valid;
    logic [LINE_W-1:0]   l1_vic_line;
    logic                l2_hit, l2_ev_valid;
    logic [L2_WAY_W-1:0] l2_hit_way;
    logic [LINE_W-1:0]   l2_ev_line;

    logic look_done, fill_take;
    logic l1_touch, l1_ins, l2_inv, l2_ins, l2_swap, evict_now;

    assign look_done = (state_q == ST_L1LOOK) && (cnt_q == CNT_W'(L1_LAT - 1));
    assign fill_take = (state_q == ST_FILL) && fill_done;
    assign l1_touch  = look_done && l1_hit;
    assign l2_inv    = look_done && !l1_hit && l2_hit;
    assign l1_ins    = l2_inv || fill_take;
    assign l2_ins    = l1_ins && l1_vic_valid;
    assign l2_swap   = l2_inv && (l1_vic_line[L2_IDX_W-1:0] == line_q[L2_IDX_W-1:0]);
    assign evict_now = l2_ins && !l2_swap && l2_ev_valid;

    xvc_l1 #(.LINE_W(LINE_W), .SETS(L1_SETS)) l1_i (
        .clk       (clk),
        .rst       (rst),
        .lk_line   (line_q),
        .hit       (l1_hit),
        .hit_way   (l1_hit_way),
        .vic_valid (l1_vic_valid),
        .vic_line  (l1_vic_line),
        .touch_en  (l1_touch),
        .ins_en    (l1_ins)
    );

    xvc_l2 #(.LINE_W(LINE_W), .SETS(L2_SETS), .WAYS(L2_WAYS)) l2_i (
        .clk      (clk),
        .rst      (rst),
        .lk_line  (line_q),
        .hit      (l2_hit),
        .hit_way  (l2_hit_way),
        .inv_en   (l2_inv),
        .ins_en   (l2_ins),
        .ins_line (l1_vic_line),
        .ins_swap (l2_swap),
        .ev_valid (l2_ev_valid),
        .ev_line  (l2_ev_line)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            src_q   <= SRC_L1;
            cnt_q   <= '0;
            line_q  <= '0;
            evict_q <= 1'b0;
        end else begin
            evict_q <= evict_now;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        line_q  <= req_addr[ADDR_W-1:OFFSET_W];
                        cnt_q   <= '0;
                        state_q <= ST_L1LOOK;
                    end
                end
                ST_L1LOOK: begin
                    if (look_done) begin
                        cnt_q <= '0;
                        if (l1_hit) begin
                            src_q   <= SRC_L1;
                            state_q <= ST_RESP;
                        end else if (l2_hit) begin
                            src_q   <= SRC_L2;
                            state_q <= ST_L2WAIT;
                        end else begin
                            src_q   <= SRC_MEM;
                            state_q <= ST_FILL;
                        end
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_L2WAIT: begin
                    if (cnt_q == CNT_W'(L2_EXTRA - 1)) state_q <= ST_RESP;
                    else                               cnt_q   <= cnt_q + 1'b1;
                end
                ST_FILL: begin
                    if (fill_done) state_q <= ST_RESP;
                end
                ST_RESP:  state_q <= ST_IDLE;
                default:  state_q <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (evict_now) evict_line_q <= l2_ev_line;
    end

    assign req_ready   = (state_q == ST_IDLE);
    assign rsp_valid   = (state_q == ST_RESP);
    assign rsp_src     = src_q;
    assign fill_valid  = (state_q == ST_FILL);
    assign fill_addr   = {line_q, {OFFSET_W{1'b0}}};
    assign evict_valid = evict_q;
    assign evict_addr  = {evict_line_q, {OFFSET_W{1'b0}}};

    AST_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_L1LOOK) |-> !(l1_hit && l2_hit)) else $error("line in both levels"); // R8

    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid) else $error("response longer than one cycle"); // R3

    AST_READY_BUSY: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready) else $error("ready during response"); // R12

    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fill_valid && !fill_done) |=> (fill_valid && $stable(fill_addr))) else $error("fill dropped"); // R4

    AST_EVICT_PULSE: assert property (@(posedge clk) disable iff (rst)
        evict_valid |=> !evict_valid) else $error("eviction longer than one cycle"); // R10

endmodule

// File: tb/xvc_ctrl_tb.sv
`timescale 1ns/1ps
module xvc_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        rsp_valid;
    logic [1:0]  rsp_src;
    logic        fill_valid;
    logic [31:0] fill_addr;
    logic        fill_done;
    logic        fill_en = 1'b0;
    logic        evict_valid;
    logic [31:0] evict_addr;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 0;

    always #10 clk = ~clk;

    assign fill_done = fill_valid & fill_en;

    xvc_ctrl dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .rsp_valid   (rsp_valid),
        .rsp_src     (rsp_src),
        .fill_valid  (fill_valid),
        .fill_addr   (fill_addr),
        .fill_done   (fill_done),
        .evict_valid (evict_valid),
        .evict_addr  (evict_addr)
    );

    // entry: {address, expected source, eviction expected, eviction address}
    // sources: 0 level one, 1 level two, 2 below; set 0 lines are multiples of 0x200
    localparam logic [66:0] VEC [20] = '{
        {32'h0000_0000, 2'd2, 1'b0, 32'h0},      // R1 empty after reset
        {32'h0000_003F, 2'd0, 1'b0, 32'h0},      // R2 offset bits ignored
        {32'h0000_0200, 2'd2, 1'b0, 32'h0},      // R5 second way filled
        {32'h0000_0000, 2'd0, 1'b0, 32'h0},      // R6 hit refreshes way 0
        {32'h0000_0400, 2'd2, 1'b0, 32'h0},      // R6 LRU way 1 replaced
        {32'h0000_0200, 2'd1, 1'b0, 32'h0},      // R7 victim found in level two
        {32'h0000_0200, 2'd0, 1'b0, 32'h0},      // R8 promoted line now in level one
        {32'h0000_0000, 2'd1, 1'b0, 32'h0},      // R9 swap, no eviction
        {32'h0000_0600, 2'd2, 1'b0, 32'h0},
        {32'h0000_0800, 2'd2, 1'b0, 32'h0},
        {32'h0000_0A00, 2'd2, 1'b0, 32'h0},
        {32'h0000_0C00, 2'd2, 1'b0, 32'h0},
        {32'h0000_0E00, 2'd2, 1'b0, 32'h0},
        {32'h0000_1000, 2'd2, 1'b0, 32'h0},
        {32'h0000_1200, 2'd2, 1'b0, 32'h0},      // level-two set 0 now full
        {32'h0000_1400, 2'd2, 1'b1, 32'h0000_0400}, // R10 R11 way 0 out
        {32'h0000_1600, 2'd2, 1'b1, 32'h0000_0800}, // R11 then way 4
        {32'h0000_0400, 2'd2, 1'b1, 32'h0000_0000}, // R11 then way 2
        {32'h0000_0625, 2'd1, 1'b0, 32'h0},      // R9 swap in a full set
        {32'h0000_0600, 2'd0, 1'b0, 32'h0}       // R8
    };
    localparam int VREQ [20] = '{1, 2, 5, 6, 6, 7, 8, 9, 6, 6, 6, 6, 6, 6, 6, 10, 11, 11, 9, 8};

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic run_req(input logic [31:0] a, input logic [1:0] es, input logic eev,
                           input logic [31:0] eea, input int fdel, input logic hold,
                           input logic [31:0] oth, input string tag);
        int n = 0;
        int lat = -1;
        int fcnt = 0;
        int evn = 0;
        int evat = -1;
        logic [31:0] eva = '0;
        logic [1:0] src = '0;
        int exp_lat;
        logic [31:0] line_a;
        line_a = a & ~32'h3F;
        exp_lat = (es == 2'd0) ? 3 : (es == 2'd1) ? 12 : 4 + fdel;
        @(negedge clk);
        chk(req_ready, "R12", {tag, " idle ready"}, 32'(req_ready), 1);
        req_valid = 1'b1;
        req_addr  = a;
        fill_en   = 1'b0;
        @(posedge clk);
        forever begin
            @(negedge clk);
            if (n == 0) begin
                if (hold) req_addr = oth;
                else      req_valid = 1'b0;
            end
            if (hold) chk(!req_ready, "R12", {tag, " ready while busy"}, 32'(req_ready), 0);
            if (fill_valid) begin
                if (fcnt == 0) chk(n == 3, "R4", {tag, " fill start"}, 32'(n), 3);
                chk(fill_addr == line_a, "R4", {tag, " fill addr"}, fill_addr, line_a);
                fcnt++;
            end
            if (evict_valid) begin
                evn++;
                eva  = evict_addr;
                evat = n;
            end
            if (rsp_valid) begin
                lat = n;
                src = rsp_src;
                req_valid = 1'b0;
                break;
            end
            if (n == 3 + fdel) fill_en = 1'b1;
            n++;
            if (n > 300) break;
        end
        fill_en = 1'b0;
        chk(lat == exp_lat, tag, "latency", 32'(lat), 32'(exp_lat));
        chk(src == es, tag, "source", 32'(src), 32'(es));
        if (es == 2'd2) chk(fcnt == fdel + 1, "R4", {tag, " fill length"}, 32'(fcnt), 32'(fdel + 1));
        else            chk(fcnt == 0, "R5", {tag, " no fill"}, 32'(fcnt), 0);
        chk(evn == int'(eev), "R10", {tag, " eviction count"}, 32'(evn), 32'(eev));
        if (eev) begin
            chk(eva == eea, "R11", {tag, " eviction addr"}, eva, eea);
            chk(evat == lat, "R10", {tag, " eviction cycle"}, 32'(evat), 32'(lat));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", "run did not end", 0, 1);
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready, "R1", "reset ready", 32'(req_ready), 1);
        chk(!rsp_valid && !fill_valid && !evict_valid, "R1", "reset outputs",
            {29'd0, rsp_valid, fill_valid, evict_valid}, 0);

        for (int i = 0; i < 20; i++)
            run_req(VEC[i][66:35], VEC[i][34:33], VEC[i][32], VEC[i][31:0], 0, 1'b0, '0,
                    $sformatf("R%0d vec%0d", VREQ[i], i));

        // R1 reset wipes all lines
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(req_ready && !rsp_valid && !fill_valid && !evict_valid, "R1", "second reset",
            {28'd0, req_ready, rsp_valid, fill_valid, evict_valid}, 32'h8);
        run_req(32'h0000_0600, 2'd2, 1'b0, '0, 0, 1'b0, '0, "R1 after reset");

        // R4 slow fill in set 1
        run_req(32'h0000_2040, 2'd2, 1'b0, '0, 5, 1'b0, '0, "R4 delayed fill");
        run_req(32'h0000_2050, 2'd0, 1'b0, '0, 0, 1'b0, '0, "R3 set 1 hit");

        // R12 request held while busy is not taken
        run_req(32'h0000_4000, 2'd2, 1'b0, '0, 0, 1'b1, 32'h0000_8000, "R12 busy");
        run_req(32'h0000_8000, 2'd2, 1'b0, '0, 0, 1'b0, '0, "R12 held one unseen");

        repeat (2) @(negedge clk);
        finish_run();
    end

endmodule